// File: doc/BRIEF.md
# Host Supervision Watchdog

This block watches an external host microcontroller. The host proves it is alive by flipping a single kick pin. Either direction of change counts. While supervision is switched on, the block counts system clock cycles. If a full timeout period passes without a kick, the block sets a sticky status flag. If the reset-out feature is also switched on, it drives a fixed-width active-low pulse on a reset line towards the host.

An expiry never resets the block itself. The count reloads and supervision carries on, so a host that stays silent gets one pulse per timeout period. Configuration comes from three plain inputs: enable, pulse-enable and the timeout length in cycles. The kick pin is asynchronous to the block clock and is synchronized inside the block.

Top module: `host_wdog`

## Requirements
- R1: While `wd_en` is low, no timeout occurs: `timeout_sts` is not set and `rst_out_n` stays high, whatever `kick_in` does.
- R2: With `wd_en` high and no kick, the timeout fires on the `timeout_cycles`-th rising clock edge at which `wd_en` is sampled high. At that edge `timeout_sts` and, when enabled, the pulse are registered.
- R3: A change of `kick_in` in either direction (0 to 1 or 1 to 0) restarts the count. A pin change made just after edge m restarts the count at edge m+3, so the next timeout is at edge m+3+`timeout_cycles`. A kick reaching the counter in the cycle of an expiry cancels that expiry.
- R4: A timeout drives `rst_out_n` low only if `pulse_en` is high at the expiring edge. Otherwise only `timeout_sts` is set.
- R5: `rst_out_n` idles high. Each pulse holds it low for exactly `PULSE_LEN` clock cycles (default 8), starting at the expiring edge.
- R6: After an expiry the count reloads and supervision continues. A host that stays silent gets another timeout `timeout_cycles` edges later.
- R7: `timeout_sts` is sticky. It stays set until `sts_clr` is high at a clock edge. An expiry at the same edge as `sts_clr` wins and leaves the flag set.
- R8: Dropping `wd_en` clears the count. After re-enable, a full `timeout_cycles` period is needed before the next timeout.
- R9: `timeout_cycles` values of 0 and 1 both mean a one-cycle period: the timeout fires on the first enabled edge.
- R10: Synchronous reset `rst` leaves `rst_out_n` high and `timeout_sts` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Supervision enable |
| pulse_en | input | 1 | Allow a reset-out pulse on expiry |
| timeout_cycles | input | CNT_W | Timeout period in clock cycles |
| kick_in | input | 1 | Asynchronous kick pin from the host |
| sts_clr | input | 1 | Clears the sticky timeout flag |
| rst_out_n | output | 1 | Active-low reset pulse to the host |
| timeout_sts | output | 1 | Sticky timeout flag |

## Verification
A corrupted count shows up as a timeout on the wrong edge. The bench therefore counts edges exactly from enable, from each kick and from each previous expiry, and checks that the flag and the pulse appear on the predicted cycle and not one cycle earlier or later. A broken synchronizer or edge detector shows up one period later, as a timeout that should have been cancelled. A wrong pulse counter is caught within `PULSE_LEN`+1 cycles by the width checks. Sticky-flag faults are seen at the first clear and at the clear-versus-expiry collision.

// File: rtl/host_wdog_pkg.sv
package host_wdog_pkg;
  // flops in the kick-pin synchronizer, before the edge-detect flop
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/host_wdog_sync.sv
module host_wdog_sync #(
  parameter int unsigned STAGES = host_wdog_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic toggle
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin};
  end

  // any level change, rising or falling
  assign toggle = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/host_wdog_timer.sv
module host_wdog_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // limits 0 and 1 both give a one-cycle period
  assign term   = (limit == '0) ? '0 : limit - 1'b1;
  assign expire = en && !restart && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst || !en || restart || expire) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/host_wdog_pulse.sv
module host_wdog_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic out_n
);
  localparam int unsigned PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    if (fire)              left_d = LEN_V;
    else if (left_q != '0) left_d = left_q - 1'b1;
    else                   left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      out_n  <= 1'b1;
    end else begin
      left_q <= left_d;
      out_n  <= (left_d == '0);
    end
  end
endmodule

// File: rtl/host_wdog.sv
module host_wdog #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_en,
  input  logic             pulse_en,
  input  logic [CNT_W-1:0] timeout_cycles,
  input  logic             kick_in,
  input  logic             sts_clr,
  output logic             rst_out_n,
  output logic             timeout_sts
);
  logic kick_evt;
  logic expire;

  host_wdog_sync #(.STAGES(host_wdog_pkg::SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .pin(kick_in), .toggle(kick_evt)
  );

  host_wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en(wd_en), .restart(kick_evt),
    .limit(timeout_cycles), .expire(expire)
  );

  host_wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(expire && pulse_en), .out_n(rst_out_n)
  );

  // sticky flag: a new expiry beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          timeout_sts <= 1'b0;
    else if (expire)  timeout_sts <= 1'b1;
    else if (sts_clr) timeout_sts <= 1'b0;
  end
endmodule

// File: rtl/host_wdog_chk.sv
module host_wdog_chk #(
  parameter int unsigned PULSE_LEN = 8
) (
  input logic clk,
  input logic rst,
  input logic wd_en,
  input logic pulse_en,
  input logic sts_clr,
  input logic rst_out_n,
  input logic timeout_sts
);
  // R1: a pulse only starts on an enabled edge
  a_r1_pulse_needs_en: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n) |-> $past(wd_en));

  // R1: the flag only rises on an enabled edge
  a_r1_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_sts) |-> $past(wd_en));

  // R4: a pulse only starts when pulse output was allowed
  a_r4_pulse_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n) |-> $past(pulse_en));

  // R7: every pulse start comes with the flag set
  a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n) |-> timeout_sts);

  // R7: without a clear the flag holds
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (timeout_sts && !sts_clr) |=> timeout_sts);

  generate
    if (PULSE_LEN > 1) begin : g_width
      // R5: a pulse lasts more than one cycle
      a_r5_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_n) |=> !rst_out_n);
    end
  endgenerate
endmodule

bind host_wdog host_wdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .wd_en(wd_en), .pulse_en(pulse_en),
  .sts_clr(sts_clr), .rst_out_n(rst_out_n), .timeout_sts(timeout_sts)
);

// File: tb/host_wdog_bench.sv
`timescale 1ns/1ps
module host_wdog_bench;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PLEN  = 8;
  localparam int unsigned T     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_en = 1'b0, pulse_en = 1'b0, kick_in = 1'b0, sts_clr = 1'b0;
  logic [CNT_W-1:0] timeout_cycles = CNT_W'(T);
  logic rst_out_n, timeout_sts;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  host_wdog #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) u_host_wdog (
    .clk(clk), .rst(rst), .wd_en(wd_en), .pulse_en(pulse_en),
    .timeout_cycles(timeout_cycles), .kick_in(kick_in), .sts_clr(sts_clr),
    .rst_out_n(rst_out_n), .timeout_sts(timeout_sts)
  );

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // disable, wait out any pulse, clear flag; caller enables after this
  task automatic fresh();
    wd_en = 1'b0;
    adv(PLEN + 2);
    sts_clr = 1'b1;
    adv(1);
    sts_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rst_out_n after reset", rst_out_n, 1'b1);
    chk("R10 timeout_sts after reset", timeout_sts, 1'b0);
  endtask

  task automatic t_disabled();
    logic seen = 1'b0;
    pulse_en = 1'b1;
    wd_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) kick_in = ~kick_in;
      adv(1);
      if (!rst_out_n || timeout_sts) seen = 1'b1;
    end
    chk("R1 no timeout while disabled", seen, 1'b0);
  endtask

  task automatic t_expiry();
    logic early = 1'b0, gap = 1'b0;
    fresh();
    pulse_en = 1'b1;
    wd_en = 1'b1;
    for (int e = 1; e < T; e++) begin
      adv(1);
      if (!rst_out_n || timeout_sts) early = 1'b1;
    end
    chk("R2 nothing before edge T", early, 1'b0);
    adv(1);
    chk("R2 pulse at edge T", rst_out_n, 1'b0);
    chk("R7 flag at edge T", timeout_sts, 1'b1);
    for (int e = 1; e < PLEN; e++) begin
      adv(1);
      if (rst_out_n) gap = 1'b1;
    end
    chk("R5 pulse held PULSE_LEN cycles", gap, 1'b0);
    adv(1);
    chk("R5 pulse ends after PULSE_LEN", rst_out_n, 1'b1);
    adv(T - PLEN - 1);
    chk("R6 high before second expiry", rst_out_n, 1'b1);
    adv(1);
    chk("R6 second pulse after reload", rst_out_n, 1'b0);
    chk("R7 flag still set", timeout_sts, 1'b1);
    wd_en = 1'b0;
    adv(PLEN + 2);
    chk("R7 flag sticky while idle", timeout_sts, 1'b1);
    sts_clr = 1'b1;
    adv(1);
    sts_clr = 1'b0;
    chk("R7 clear drops flag", timeout_sts, 1'b0);
  endtask

  task automatic t_kick_edges();
    for (int run = 0; run < 2; run++) begin
      logic early = 1'b0;
      fresh();
      pulse_en = 1'b1;
      wd_en = 1'b1;
      adv(5);
      kick_in = ~kick_in;  // rising in run 0, falling in run 1
      for (int e = 6; e < 8 + T; e++) begin
        adv(1);
        if (!rst_out_n || timeout_sts) early = 1'b1;
      end
      chk(run == 0 ? "R3 rising kick delays timeout" : "R3 falling kick delays timeout",
          early, 1'b0);
      adv(1);
      chk(run == 0 ? "R3 timeout after rising kick" : "R3 timeout after falling kick",
          rst_out_n, 1'b0);
    end
  endtask

  task automatic t_kick_stream();
    logic seen = 1'b0;
    fresh();
    pulse_en = 1'b1;
    wd_en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (i % 5 == 0) kick_in = ~kick_in;
      adv(1);
      if (!rst_out_n || timeout_sts) seen = 1'b1;
    end
    chk("R3 regular kicks prevent timeout", seen, 1'b0);
  endtask

  task automatic t_pulse_off();
    logic low = 1'b0;
    fresh();
    pulse_en = 1'b0;
    wd_en = 1'b1;
    adv(T);
    chk("R4 flag set with pulse disabled", timeout_sts, 1'b1);
    for (int i = 0; i < 2 * T; i++) begin
      adv(1);
      if (!rst_out_n) low = 1'b1;
    end
    chk("R4 no pulse when disabled", low, 1'b0);
    pulse_en = 1'b1;
  endtask

  task automatic t_clear_race();
    fresh();
    wd_en = 1'b1;
    adv(T - 1);
    sts_clr = 1'b1;
    adv(1);
    sts_clr = 1'b0;
    chk("R7 expiry beats clear", timeout_sts, 1'b1);
    sts_clr = 1'b1;
    adv(1);
    sts_clr = 1'b0;
    chk("R7 later clear works", timeout_sts, 1'b0);
  endtask

  task automatic t_reenable();
    logic early = 1'b0;
    fresh();
    wd_en = 1'b1;
    adv(7);
    wd_en = 1'b0;
    adv(3);
    wd_en = 1'b1;
    for (int e = 1; e < T; e++) begin
      adv(1);
      if (timeout_sts) early = 1'b1;
    end
    chk("R8 full period after re-enable", early, 1'b0);
    adv(1);
    chk("R8 timeout after full period", timeout_sts, 1'b1);
  endtask

  task automatic t_min();
    for (int v = 0; v < 2; v++) begin
      fresh();
      pulse_en = 1'b0;
      timeout_cycles = CNT_W'(v);
      wd_en = 1'b1;
      adv(1);
      chk(v == 0 ? "R9 limit 0 fires at once" : "R9 limit 1 fires at once",
          timeout_sts, 1'b1);
    end
    timeout_cycles = CNT_W'(T);
    pulse_en = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    adv(3);
    rst = 1'b0;
    adv(1);
    t_reset();
    t_disabled();
    t_expiry();
    t_kick_edges();
    t_kick_stream();
    t_pulse_off();
    t_clear_race();
    t_reenable();
    t_min();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule